// File: doc/BRIEF.md
# Double-Fault Crash Dump Capture

This block gathers the processor's fault context into one packed vector that the reset controller keeps across a reset, so software can find out after a reset where execution stopped. The core supplies five live values:
- the last exception address
- the last exception PC
- the last data access address
- the next PC
- the current PC

These values pass through the block without a register. When the core hangs on a bus access, the dump therefore shows the frozen PC and data address up to the moment the reset strikes.

When the core reports a double fault, the block copies the exception address and exception PC present at that clock edge into a previous slot. It then raises a validity flag. The next fault then shows up in the current words, and both fault locations stay visible. The previous slot and its flag are cleared only by reset.

Top module: `cdump_capture`

## Requirements
- R1: Words 0 to 4 of the dump (bits [32k+31:32k] for word k) carry, in this order, the exception address, exception PC, data access address, next PC and current PC. Each word follows its input combinationally, within the same cycle and with no clock edge.
- R2: Word 5 (bits [191:160]) holds the previous exception address, word 6 (bits [223:192]) holds the previous exception PC, and bit 224 is the previous-valid flag.
- R3: While reset is asserted, words 5 and 6 read zero and the previous-valid flag reads 0, whatever the inputs are.
- R4: On a clock edge with the double-fault input low, words 5 and 6 and the flag keep their values. If no fault has occurred since reset, they stay zero and 0.
- R5: On a clock edge with the double-fault input high, words 5 and 6 take the exception address and exception PC present at that edge, and the flag reads 1 after the edge. This holds even when those inputs changed earlier in the same cycle.
- R6: Once set, the flag stays 1 until reset. A later double fault overwrites words 5 and 6 with the exception context present at that later edge.
- R7: Asserting the active-low reset in the middle of a run clears words 5 and 6 and the flag at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dfault_i | input | 1 | Double-fault event from the core, sampled on the rising edge |
| exc_addr_i | input | 32 | Last exception address |
| exc_pc_i | input | 32 | Last exception PC |
| data_addr_i | input | 32 | Last data access address |
| next_pc_i | input | 32 | Next PC |
| cur_pc_i | input | 32 | Current PC |
| dump_o | output | 225 | Packed dump: seven words plus the previous-valid flag in bit 224 |

## Verification
Two functions can fall in the same cycle: the live exception context can change while the double-fault event is high, so capture and pass-through act together. The bench provokes this by loading a new exception address and PC in the same cycle that it raises the double-fault input. It then requires the previous slot to hold exactly the values present at the edge, while the current words already show the next fault driven after that edge. A behavioural model, compared on every clock and also between edges, judges both the captured and the live words.

// File: rtl/cdump_pkg.sv
package cdump_pkg;

    // Word positions inside the packed dump; the reset controller decodes them.
    typedef enum int unsigned {
        WI_EXC_ADDR  = 0,
        WI_EXC_PC    = 1,
        WI_DATA_ADDR = 2,
        WI_NEXT_PC   = 3,
        WI_CUR_PC    = 4,
        WI_PREV_ADDR = 5,
        WI_PREV_PC   = 6
    } word_idx_e;

    localparam int unsigned CUR_WORDS   = 5;
    localparam int unsigned PREV_WORDS  = 2;
    localparam int unsigned TOTAL_WORDS = CUR_WORDS + PREV_WORDS;

endpackage

// File: rtl/cdump_prev_slot.sv
module cdump_prev_slot #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         dfault_i,
    input  logic [W-1:0] exc_addr_i,
    input  logic [W-1:0] exc_pc_i,
    output logic [W-1:0] prev_addr_o,
    output logic [W-1:0] prev_pc_o,
    output logic         prev_vld_o
);

    typedef struct packed {
        logic [W-1:0] addr;
        logic [W-1:0] pc;
        logic         vld;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (dfault_i) begin
            slot_d.addr = exc_addr_i;
            slot_d.pc   = exc_pc_i;
            slot_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign prev_addr_o = slot_q.addr;
    assign prev_pc_o   = slot_q.pc;
    assign prev_vld_o  = slot_q.vld;

    // R5
    capture_takes_edge_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dfault_i |=> (prev_addr_o == $past(exc_addr_i)) && (prev_pc_o == $past(exc_pc_i)) && prev_vld_o);

    // R4
    hold_without_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dfault_i |=> $stable(prev_addr_o) && $stable(prev_pc_o) && $stable(prev_vld_o));

    // R6
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prev_vld_o |=> prev_vld_o);

    // R3
    empty_slot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !prev_vld_o |-> (prev_addr_o == '0) && (prev_pc_o == '0));

endmodule

// File: rtl/cdump_pack.sv
module cdump_pack #(
    parameter int unsigned W  = 32,
    parameter int unsigned NW = 7
) (
    input  logic [W-1:0]  words_i [NW],
    input  logic          prev_vld_i,
    output logic [NW*W:0] dump_o
);

    localparam int unsigned FLAG_BIT = NW * W;

    for (genvar k = 0; k < NW; k++) begin : g_word
        assign dump_o[k*W +: W] = words_i[k];
    end

    assign dump_o[FLAG_BIT] = prev_vld_i;

endmodule

// File: rtl/cdump_capture.sv
module cdump_capture
    import cdump_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     dfault_i,
    input  logic [W-1:0]             exc_addr_i,
    input  logic [W-1:0]             exc_pc_i,
    input  logic [W-1:0]             data_addr_i,
    input  logic [W-1:0]             next_pc_i,
    input  logic [W-1:0]             cur_pc_i,
    output logic [TOTAL_WORDS*W:0]   dump_o
);

    localparam int unsigned FLAG_BIT = TOTAL_WORDS * W;

    logic [W-1:0] words [TOTAL_WORDS];
    logic [W-1:0] prev_addr, prev_pc;
    logic         prev_vld;

    cdump_prev_slot #(.W(W)) u_slot (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .dfault_i   (dfault_i),
        .exc_addr_i (exc_addr_i),
        .exc_pc_i   (exc_pc_i),
        .prev_addr_o(prev_addr),
        .prev_pc_o  (prev_pc),
        .prev_vld_o (prev_vld)
    );

    assign words[WI_EXC_ADDR]  = exc_addr_i;
    assign words[WI_EXC_PC]    = exc_pc_i;
    assign words[WI_DATA_ADDR] = data_addr_i;
    assign words[WI_NEXT_PC]   = next_pc_i;
    assign words[WI_CUR_PC]    = cur_pc_i;
    assign words[WI_PREV_ADDR] = prev_addr;
    assign words[WI_PREV_PC]   = prev_pc;

    cdump_pack #(.W(W), .NW(TOTAL_WORDS)) u_pack (
        .words_i   (words),
        .prev_vld_i(prev_vld),
        .dump_o    (dump_o)
    );

    // R1
    live_pc_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dump_o[W-1:0] == exc_addr_i) && (dump_o[WI_CUR_PC*W +: W] == cur_pc_i));

    // R2
    flag_position_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dfault_i |=> dump_o[FLAG_BIT] && (dump_o[WI_PREV_ADDR*W +: W] == $past(exc_addr_i)));

endmodule

// File: tb/cdump_capture_test.sv
module cdump_capture_test;

    localparam int W = 32;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          dfault_i = 1'b0;
    logic [W-1:0]  exc_addr_i = '0, exc_pc_i = '0, data_addr_i = '0, next_pc_i = '0, cur_pc_i = '0;
    logic [7*W:0]  dump_o;

    logic [W-1:0]  m_prev_addr = '0, m_prev_pc = '0;
    logic          m_vld = 1'b0;
    int            n_checks = 0, n_fail = 0;

    always #5 clk_i = ~clk_i;

    cdump_capture #(.W(W)) uut (
        .clk_i(clk_i), .rst_ni(rst_ni), .dfault_i(dfault_i),
        .exc_addr_i(exc_addr_i), .exc_pc_i(exc_pc_i), .data_addr_i(data_addr_i),
        .next_pc_i(next_pc_i), .cur_pc_i(cur_pc_i), .dump_o(dump_o)
    );

    function automatic logic [7*W:0] expected();
        return {m_vld, m_prev_pc, m_prev_addr, cur_pc_i, next_pc_i, data_addr_i, exc_pc_i, exc_addr_i};
    endfunction

    task automatic check(input string tag);
        logic [7*W:0] e;
        e = expected();
        n_checks++;
        if (dump_o !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, dump_o, e);
        end
    endtask

    task automatic randomize_live();
        exc_addr_i  = $urandom;
        exc_pc_i    = $urandom;
        data_addr_i = $urandom;
        next_pc_i   = $urandom;
        cur_pc_i    = $urandom;
    endtask

    // Compare between edges, then advance the model across the next rising edge.
    task automatic cycle(input string tag);
        @(negedge clk_i);
        check(tag);
        @(posedge clk_i);
        if (rst_ni && dfault_i) begin
            m_prev_addr = exc_addr_i;
            m_prev_pc   = exc_pc_i;
            m_vld       = 1'b1;
        end
        #1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R3: reset state with arbitrary live inputs, even with a fault pulse
        for (int i = 0; i < 3; i++) begin
            randomize_live();
            dfault_i = (i == 1);
            cycle("R3");
        end
        dfault_i = 1'b0;
        rst_ni = 1'b1;

        // R4: no fault, previous slot stays empty
        for (int i = 0; i < 5; i++) begin
            randomize_live();
            cycle("R4");
        end

        // R1: combinational pass-through without a clock edge
        @(negedge clk_i);
        exc_addr_i = 32'h0000_1000;
        cur_pc_i   = 32'h0000_2004;
        #1 check("R1");
        next_pc_i   = 32'h0000_2008;
        data_addr_i = 32'h4000_0010;
        #1 check("R1");
        @(posedge clk_i);
        #1;

        // R5: new fault context arrives in the same cycle as the double-fault event
        exc_addr_i = 32'hDEAD_0001;
        exc_pc_i   = 32'h8000_0100;
        dfault_i   = 1'b1;
        cycle("R5");
        dfault_i   = 1'b0;
        randomize_live();
        cycle("R5");
        cycle("R2");

        // R1: hung bus, inputs frozen
        for (int i = 0; i < 4; i++) cycle("R1");

        // R4: later cycles without a fault hold the slot
        for (int i = 0; i < 4; i++) begin
            randomize_live();
            cycle("R4");
        end

        // R6: second double fault overwrites the slot
        exc_addr_i = 32'hBEEF_0002;
        exc_pc_i   = 32'h8000_0200;
        dfault_i   = 1'b1;
        cycle("R6");
        dfault_i   = 1'b0;
        for (int i = 0; i < 4; i++) begin
            randomize_live();
            cycle("R6");
        end

        // R6: two consecutive fault edges, the last one wins
        dfault_i = 1'b1;
        randomize_live();
        cycle("R6");
        randomize_live();
        cycle("R6");
        dfault_i = 1'b0;
        cycle("R6");

        // R7: asynchronous reset in the middle of the run
        rst_ni = 1'b0;
        m_prev_addr = '0;
        m_prev_pc   = '0;
        m_vld       = 1'b0;
        #1 check("R7");
        cycle("R7");
        rst_ni = 1'b1;
        for (int i = 0; i < 3; i++) begin
            randomize_live();
            cycle("R7");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule